// File: doc/BRIEF.md
# System Control Block Command Decoder

This block sits between the host and the two execution engines of a network controller. The host writes a 16-bit command word. The block takes each write, flagged by a one-cycle strobe, as one request. It splits the word into a command-unit control code, a receive-unit control code, a software-reset request and a nibble of acknowledge bits. It then updates the command-unit (CU) and receive-unit (RU) states.

The command and receive engines report events to the block as single-cycle pulses. These are: a command finished and asked for an interrupt, a frame arrived, and either unit left its active state. The block latches these pulses until the host acknowledges them. It folds the latched events and both unit states into one packed status word, and it raises an interrupt while any event is pending. It also issues a one-cycle pulse that tells the command engine to fetch the head of its command list, and a one-cycle software-reset pulse. It holds a sticky flag for unrecognised control codes.

Top module: `scb_cmd_decoder`

## Requirements
- R1: Command-word fields are fixed. Bits 10:8 carry the CU code, bits 6:4 carry the RU code and bit 7 requests a software reset. Bits 15:12 are acknowledge bits for event bits 15 (command done with interrupt), 14 (frame received), 13 (CU left active) and 12 (RU left active). After `rst_ni`, the CU is idle (0), the RU is suspended (1), the status word is 0x0010, and all pulses and flags are low.
- R2: CU code 1 sets the CU to active (2). Code 0 leaves it unchanged. Every state change becomes visible on the first clock edge that samples the strobe. Without a strobe, neither state changes.
- R3: CU code 4 sets the CU to suspended (1) and sets event bit 13.
- R4: RU code 1 (start) or 2 (resume) sets the RU to ready (4). RU code 0 leaves it unchanged.
- R5: RU code 3 (suspend) or 4 (abort) sets the RU to suspended (1) and sets event bit 12.
- R6: An unknown code leaves that unit's state unchanged and sets `cmd_err_o`. For the CU, the unknown codes are 2, 3, 5, 6 and 7. For the RU, they are 5, 6 and 7. `cmd_err_o` stays high until a reset.
- R7: Each event pulse sets its status bit. `evt_cx_i` sets bit 15, `evt_fr_i` sets bit 14, `evt_cna_i` sets bit 13 and `evt_rnr_i` sets bit 12. The bit stays set until it is acknowledged. When a set and an acknowledge of the same bit fall in the same cycle, the set wins.
- R8: A strobed command word clears each event bit whose acknowledge bit is 1. It leaves the other event bits alone.
- R9: The status word holds the event bits in 15:12, the CU state in 9:8 and the RU state in 6:4. All other bits are 0.
- R10: `irq_o` is high exactly when any status bit 15:12 is set.
- R11: A command with bit 7 set overrides that word's codes. On the next edge, the CU becomes idle, the RU becomes suspended, the event bits (including same-cycle pulses) and `cmd_err_o` clear, and `sw_reset_o` pulses for one cycle.
- R12: After a strobed command, `list_start_o` pulses for one cycle if two conditions hold. First, the resulting CU state is not suspended. Second, either `list_busy_i` is low or the word requested a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle strobe for a host command write |
| cmd_word_i | input | 16 | Host command word |
| evt_cx_i | input | 1 | Command finished with interrupt request |
| evt_fr_i | input | 1 | Frame received |
| evt_cna_i | input | 1 | CU left the active state |
| evt_rnr_i | input | 1 | RU left the active state |
| list_busy_i | input | 1 | A command list is in progress |
| cu_state_o | output | 2 | CU state: 0 idle, 1 suspended, 2 active |
| ru_state_o | output | 3 | RU state: 0 idle, 1 suspended, 4 ready |
| status_o | output | 16 | Packed status word |
| irq_o | output | 1 | Interrupt request |
| sw_reset_o | output | 1 | Software-reset pulse |
| list_start_o | output | 1 | Pulse to fetch the head of the command list |
| cmd_err_o | output | 1 | Sticky flag for an unknown control code |

## Verification
The bench builds the decoder with its default parameters: four event bits and 3-bit control codes. This gives the random phase a 1-in-8 chance of hitting each code, so every valid and invalid CU and RU code occurs many times. Events, acknowledges and soft resets overlap often in the same cycle. This exercises the set-beats-acknowledge and reset-beats-everything priorities. The random phase also toggles `list_busy_i` against reset-carrying words, which covers the list-start bypass.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned CMD_W    = 16;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned NUM_EVT  = 4;
  localparam int unsigned CUC_LSB  = 8;
  localparam int unsigned RUC_LSB  = 4;
  localparam int unsigned SRST_BIT = 7;
  localparam int unsigned ACK_LSB  = 12;
  localparam int unsigned CU_W     = 2;
  localparam int unsigned RU_W     = 3;

  // event index inside the latched nibble (status bit = ACK_LSB + index)
  localparam int unsigned EVT_RNR = 0;
  localparam int unsigned EVT_CNA = 1;
  localparam int unsigned EVT_FR  = 2;
  localparam int unsigned EVT_CX  = 3;

  typedef enum logic [CU_W-1:0] {
    CU_IDLE   = 2'd0,
    CU_SUSP   = 2'd1,
    CU_ACTIVE = 2'd2
  } cu_state_e;

  typedef enum logic [RU_W-1:0] {
    RU_IDLE  = 3'd0,
    RU_SUSP  = 3'd1,
    RU_READY = 3'd4
  } ru_state_e;

  localparam logic [CODE_W-1:0] CUC_NOP   = 3'd0;
  localparam logic [CODE_W-1:0] CUC_START = 3'd1;
  localparam logic [CODE_W-1:0] CUC_ABORT = 3'd4;

  localparam logic [CODE_W-1:0] RUC_NOP    = 3'd0;
  localparam logic [CODE_W-1:0] RUC_START  = 3'd1;
  localparam logic [CODE_W-1:0] RUC_RESUME = 3'd2;
  localparam logic [CODE_W-1:0] RUC_SUSP   = 3'd3;
  localparam logic [CODE_W-1:0] RUC_ABORT  = 3'd4;
endpackage

// File: rtl/scb_cu_ctrl.sv
module scb_cu_ctrl
  import scb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              soft_rst_i,
  input  logic [CODE_W-1:0] code_i,
  output cu_state_e         state_o,
  output cu_state_e         state_nxt_o,
  output logic              left_active_o,
  output logic              bad_code_o
);
  cu_state_e state_q, state_d;
  logic      bad;

  always_comb begin
    state_d = state_q;
    bad     = 1'b0;
    if (req_i) begin
      unique case (code_i)
        CUC_NOP:   ;
        CUC_START: state_d = CU_ACTIVE;
        CUC_ABORT: state_d = CU_SUSP;
        default:   bad = 1'b1;
      endcase
    end
    if (soft_rst_i) state_d = CU_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CU_IDLE;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign state_nxt_o   = state_d;
  assign left_active_o = req_i && (code_i == CUC_ABORT);
  assign bad_code_o    = bad;
endmodule

// File: rtl/scb_ru_ctrl.sv
module scb_ru_ctrl
  import scb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              soft_rst_i,
  input  logic [CODE_W-1:0] code_i,
  output ru_state_e         state_o,
  output logic              left_active_o,
  output logic              bad_code_o
);
  ru_state_e state_q, state_d;
  logic      bad;
  logic      leave;

  always_comb begin
    state_d = state_q;
    bad     = 1'b0;
    leave   = 1'b0;
    if (req_i) begin
      unique case (code_i)
        RUC_NOP: ;
        RUC_START, RUC_RESUME: state_d = RU_READY;
        RUC_SUSP, RUC_ABORT: begin
          state_d = RU_SUSP;
          leave   = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
    if (soft_rst_i) state_d = RU_SUSP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RU_SUSP;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign left_active_o = leave;
  assign bad_code_o    = bad;
endmodule

// File: rtl/scb_evt_latch.sv
module scb_evt_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] evt_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (clr_all_i) q <= 1'b0;
      else                q <= (q & ~ack_i[i]) | set_i[i];  // new event beats ack
    end
    assign evt_o[i] = q;
  end
endmodule

// File: rtl/scb_cmd_decoder.sv
module scb_cmd_decoder
  import scb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             evt_cx_i,
  input  logic             evt_fr_i,
  input  logic             evt_cna_i,
  input  logic             evt_rnr_i,
  input  logic             list_busy_i,
  output logic [CU_W-1:0]  cu_state_o,
  output logic [RU_W-1:0]  ru_state_o,
  output logic [CMD_W-1:0] status_o,
  output logic             irq_o,
  output logic             sw_reset_o,
  output logic             list_start_o,
  output logic             cmd_err_o
);
  logic [CODE_W-1:0]  cu_code, ru_code;
  logic [NUM_EVT-1:0] ack, set, evt;
  logic               soft_rst;
  cu_state_e          cu_q, cu_nxt;
  ru_state_e          ru_q;
  logic               cu_leave, ru_leave, cu_bad, ru_bad;
  logic               err_q, swr_q, start_q;
  logic               unused_cmd_bits;

  assign cu_code  = cmd_word_i[CUC_LSB +: CODE_W];
  assign ru_code  = cmd_word_i[RUC_LSB +: CODE_W];
  assign soft_rst = cmd_valid_i && cmd_word_i[SRST_BIT];
  assign ack      = cmd_valid_i ? cmd_word_i[ACK_LSB +: NUM_EVT] : '0;
  assign unused_cmd_bits = ^{cmd_word_i[11], cmd_word_i[3:0]};

  scb_cu_ctrl u_cu (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cmd_valid_i),
    .soft_rst_i   (soft_rst),
    .code_i       (cu_code),
    .state_o      (cu_q),
    .state_nxt_o  (cu_nxt),
    .left_active_o(cu_leave),
    .bad_code_o   (cu_bad)
  );

  scb_ru_ctrl u_ru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cmd_valid_i),
    .soft_rst_i   (soft_rst),
    .code_i       (ru_code),
    .state_o      (ru_q),
    .left_active_o(ru_leave),
    .bad_code_o   (ru_bad)
  );

  always_comb begin
    set          = '0;
    set[EVT_CX]  = evt_cx_i;
    set[EVT_FR]  = evt_fr_i;
    set[EVT_CNA] = evt_cna_i | cu_leave;
    set[EVT_RNR] = evt_rnr_i | ru_leave;
  end

  scb_evt_latch #(.N(NUM_EVT)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(soft_rst),
    .ack_i    (ack),
    .set_i    (set),
    .evt_o    (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      swr_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      err_q   <= soft_rst ? 1'b0 : (err_q | cu_bad | ru_bad);
      swr_q   <= soft_rst;
      // soft reset nulls the list pointer, so busy is ignored then
      start_q <= cmd_valid_i && (cu_nxt != CU_SUSP) && (soft_rst || !list_busy_i);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ACK_LSB +: NUM_EVT] = evt;
    status_o[CUC_LSB +: CU_W]    = cu_q;
    status_o[RUC_LSB +: RU_W]    = ru_q;
  end

  assign cu_state_o   = cu_q;
  assign ru_state_o   = ru_q;
  assign irq_o        = |evt;
  assign sw_reset_o   = swr_q;
  assign list_start_o = start_q;
  assign cmd_err_o    = err_q;
endmodule

// File: rtl/scb_cmd_decoder_chk.sv
module scb_cmd_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [15:0] cmd_word_i,
  input logic        evt_fr_i,
  input logic [1:0]  cu_state_o,
  input logic [2:0]  ru_state_o,
  input logic [15:0] status_o,
  input logic        irq_o,
  input logic        sw_reset_o,
  input logic        list_start_o,
  input logic        cmd_err_o
);
  logic req;
  assign req = cmd_valid_i && !cmd_word_i[7];

  p_cu_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && cmd_word_i[10:8] == 3'd1 |=> cu_state_o == 2'd2);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(cu_state_o) && $stable(ru_state_o));

  p_cu_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && cmd_word_i[10:8] == 3'd4 |=> cu_state_o == 2'd1 && status_o[13]);

  p_ru_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && (cmd_word_i[6:4] == 3'd1 || cmd_word_i[6:4] == 3'd2) |=> ru_state_o == 3'd4);

  p_ru_susp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && (cmd_word_i[6:4] == 3'd3 || cmd_word_i[6:4] == 3'd4) |=> ru_state_o == 3'd1 && status_o[12]);

  p_bad_cu_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && cmd_word_i[10:8] inside {3'd2, 3'd3, 3'd5, 3'd6, 3'd7} |=> cmd_err_o && $stable(cu_state_o));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o && !(cmd_valid_i && cmd_word_i[7]) |=> cmd_err_o);

  p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && cmd_word_i[14] && !evt_fr_i |=> !status_o[14]);

  p_fr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_fr_i && !(cmd_valid_i && cmd_word_i[7]) |=> status_o[14]);

  p_irq_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(cmd_valid_i));

  p_soft_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_word_i[7] |=> cu_state_o == 2'd0 && ru_state_o == 3'd1
      && sw_reset_o && !irq_o && !cmd_err_o && list_start_o);

  p_start_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_start_o |-> $past(cmd_valid_i) && cu_state_o != 2'd1);
endmodule

bind scb_cmd_decoder scb_cmd_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_word_i  (cmd_word_i),
  .evt_fr_i    (evt_fr_i),
  .cu_state_o  (cu_state_o),
  .ru_state_o  (ru_state_o),
  .status_o    (status_o),
  .irq_o       (irq_o),
  .sw_reset_o  (sw_reset_o),
  .list_start_o(list_start_o),
  .cmd_err_o   (cmd_err_o)
);

// File: tb/sim_scb_cmd_decoder.sv
module sim_scb_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_v = 1'b0;
  logic [15:0] cmd_w = '0;
  logic        e_cx = 0, e_fr = 0, e_cna = 0, e_rnr = 0, busy = 0;
  logic [1:0]  cu_o;
  logic [2:0]  ru_o;
  logic [15:0] st_o;
  logic        irq_o, swr_o, start_o, err_o;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scb_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_v), .cmd_word_i(cmd_w),
    .evt_cx_i(e_cx), .evt_fr_i(e_fr), .evt_cna_i(e_cna), .evt_rnr_i(e_rnr),
    .list_busy_i(busy), .cu_state_o(cu_o), .ru_state_o(ru_o), .status_o(st_o),
    .irq_o(irq_o), .sw_reset_o(swr_o), .list_start_o(start_o), .cmd_err_o(err_o)
  );

  // behavioural reference
  int m_cu, m_ru, m_evt, m_err, m_swr, m_start;
  always @(posedge clk or negedge rst_n) begin
    int cuc, ruc, ev, cu, ru, err;
    if (!rst_n) begin
      m_cu = 0; m_ru = 1; m_evt = 0; m_err = 0; m_swr = 0; m_start = 0;
    end else begin
      cu = m_cu; ru = m_ru; ev = m_evt; err = m_err;
      cuc = int'(cmd_w[10:8]); ruc = int'(cmd_w[6:4]);
      if (cmd_v) begin
        ev = ev & ~int'(cmd_w[15:12]);
        if (cuc == 1) cu = 2;
        else if (cuc == 4) begin cu = 1; ev = ev | 2; end
        else if (cuc != 0) err = 1;
        if (ruc == 1 || ruc == 2) ru = 4;
        else if (ruc == 3 || ruc == 4) begin ru = 1; ev = ev | 1; end
        else if (ruc != 0) err = 1;
      end
      ev = ev | (e_cx ? 8 : 0) | (e_fr ? 4 : 0) | (e_cna ? 2 : 0) | (e_rnr ? 1 : 0);
      m_swr = (cmd_v && cmd_w[7]) ? 1 : 0;
      if (m_swr == 1) begin cu = 0; ru = 1; ev = 0; err = 0; end
      m_start = (cmd_v && cu != 1 && (cmd_w[7] || !busy)) ? 1 : 0;
      m_cu = cu; m_ru = ru; m_evt = ev; m_err = err;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    chk("R2 cu_state", int'(cu_o), m_cu);
    chk("R4 ru_state", int'(ru_o), m_ru);
    chk("R9 status", int'(st_o), (m_evt << 12) | (m_cu << 8) | (m_ru << 4));
    chk("R10 irq", int'(irq_o), (m_evt != 0) ? 1 : 0);
    chk("R6 cmd_err", int'(err_o), m_err);
    chk("R11 sw_reset", int'(swr_o), m_swr);
    chk("R12 list_start", int'(start_o), m_start);
  end

  task automatic send(logic [15:0] w);
    cmd_v = 1'b1; cmd_w = w;
    @(negedge clk);
    cmd_v = 1'b0; cmd_w = '0;
  endtask

  task automatic pulse_fr();
    e_fr = 1'b1;
    @(negedge clk);
    e_fr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", int'(st_o), 16'h0010);
    chk("R1 reset cu", int'(cu_o), 0);
    chk("R1 reset irq", int'(irq_o), 0);

    send(16'h0100);
    chk("R2 cu start", int'(st_o), 16'h0210);
    chk("R12 start pulse", int'(start_o), 1);
    send(16'h0010);
    chk("R4 ru start", int'(st_o), 16'h0240);
    pulse_fr();
    chk("R7 frame event", int'(st_o), 16'h4240);
    chk("R10 irq high", int'(irq_o), 1);
    send(16'h4000);
    chk("R8 ack clears", int'(st_o), 16'h0240);
    chk("R10 irq low", int'(irq_o), 0);
    // same-cycle set and ack: set wins
    e_fr = 1'b1; send(16'h4000); e_fr = 1'b0;
    chk("R7 set beats ack", int'(st_o[14]), 1);
    send(16'h4400);
    chk("R3 cu abort", int'(st_o), 16'h2140);
    chk("R12 no start when suspended", int'(start_o), 0);
    send(16'h0030);
    chk("R5 ru suspend", int'(st_o), 16'h3110);
    send(16'h0200);
    chk("R6 bad cu code err", int'(err_o), 1);
    chk("R6 bad cu code state", int'(cu_o), 1);
    send(16'h0070);
    chk("R6 bad ru code state", int'(ru_o), 1);
    chk("R1 field map ru", int'(st_o[6:4]), 1);
    busy = 1'b1;
    send(16'h0190);
    chk("R11 soft reset status", int'(st_o), 16'h0010);
    chk("R11 sw_reset pulse", int'(swr_o), 1);
    chk("R11 err cleared", int'(err_o), 0);
    chk("R12 start despite busy", int'(start_o), 1);
    @(negedge clk);
    chk("R11 pulse one cycle", int'(swr_o), 0);
    send(16'h0100);
    chk("R12 busy blocks start", int'(start_o), 0);
    busy = 1'b0;

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 6) != 0) w[7] = 1'b0;
      cmd_v = ($urandom % 2) == 0;
      cmd_w = w;
      e_cx  = ($urandom % 5) == 0;
      e_fr  = ($urandom % 5) == 0;
      e_cna = ($urandom % 7) == 0;
      e_rnr = ($urandom % 7) == 0;
      busy  = ($urandom % 2) == 0;
      @(negedge clk);
    end
    cmd_v = 0; e_cx = 0; e_fr = 0; e_cna = 0; e_rnr = 0;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule